// File: doc/BRIEF.md
# Interleaved I/Q Input Data Assembler

This block sits at the entry of a quadrature upconverter data path and turns the incoming baseband stream into aligned I/Q sample pairs. It generates a data clock for the upstream source by dividing the system clock by a programmable ratio. All capture logic runs on the system clock and acts only in the cycle where the data clock rises.

Two capture modes share one framing scheme. In parallel mode, one 16-bit word arrives on each data-clock rising edge, alternating I then Q. In dual-serial mode, two single-bit lines carry I and Q, MSB first, and every 16 rising edges complete one word on each line. A transmit-enable input frames each burst. The first capture after enable goes high is always an I word (or the first bit of a frame), so enable sets the I/Q phase. While enable is low the port is ignored and zeros are forced onto the outputs to flush the downstream filters.

Top module: `iq_input_assembler`

## Requirements
- R1: `data_clk` toggles every `div_half`+1 system clocks, giving a period of 2×(`div_half`+1) system clocks, and runs whether `tx_en` is high or low.
- R2: While `dclk_out_en` is 0, `data_clk` is held low. It resumes toggling when the bit is set again.
- R3: In parallel mode (`mode_sel`=0), the first word captured at a data-clock rise with `tx_en` high is taken as I. The next is taken as Q, and the two keep alternating for as long as `tx_en` stays high.
- R4: `out_valid` is high for exactly one system clock, in the cycle after the edge that captures the last part of a pair. `i_out` and `q_out` hold that pair until the next pair completes.
- R5: In dual-serial mode (`mode_sel`=1), `ser_i` and `ser_q` are sampled on each data-clock rise, MSB first. After 16 rises with `tx_en` high, one pair is output with each word in two's complement.
- R6: One system clock after `tx_en` is sampled low, `i_out` and `q_out` are zero and `out_valid` is low. This lasts as long as `tx_en` stays low.
- R7: If `tx_en` falls partway through a pair or a serial frame, the partial sample is discarded and no output is produced. The next burst restarts with an I word or bit 15.
- R8: `mode_sel` is taken only while `tx_en` is low. A change of `mode_sel` during a burst has no effect on that burst.
- R9: During reset, `i_out`, `q_out`, `out_valid` and `data_clk` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | Half-period of the data clock minus one, in system clocks |
| dclk_out_en | input | 1 | Drives the data clock onto `data_clk` when high |
| mode_sel | input | 1 | 0 = interleaved parallel words, 1 = dual serial streams |
| tx_en | input | 1 | Burst framing; a rise sets I/Q phase, low flushes zeros |
| par_data | input | W | Parallel word input |
| ser_i | input | 1 | Serial I bit stream |
| ser_q | input | 1 | Serial Q bit stream |
| data_clk | output | 1 | Data clock for the upstream source |
| i_out | output | W | Assembled I sample |
| q_out | output | W | Assembled Q sample |
| out_valid | output | 1 | One-cycle strobe per completed pair |

## Verification
The bench checks that a pair is released only once both halves are in. A design that released a pair early would put out a stale Q, and the scoreboard would find an extra item. Bursts that end after an odd number of words, or after seven serial bits, test that the partial state is dropped. A design that kept the phase or bit count across bursts would swap I with Q, or shift bits out of place, in the next burst. The bench also flips `mode_sel` in the middle of a parallel burst, measures the divided clock period after a ratio change, and checks that the outputs are zeroed one cycle after enable is removed. This catches a flush that lags or fails to clear the held pair.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } iqa_mode_e;
endpackage

// File: rtl/iqa_dclk_gen.sv
module iqa_dclk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_cnt,
  input  logic             pin_en,
  output logic             rise_stb,
  output logic             dclk_pin
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap     = (cnt_q >= half_cnt);
  assign rise_stb = wrap && !phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      dclk_pin <= 1'b0;
    end else if (wrap) begin
      cnt_q    <= '0;
      phase_q  <= ~phase_q;
      dclk_pin <= ~phase_q & pin_en;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      dclk_pin <= phase_q & pin_en;
    end
  end

  p_pin_off_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(pin_en) |-> !dclk_pin);
endmodule

// File: rtl/iqa_par_capture.sv
module iqa_par_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] word_in,
  output logic         done,
  output logic [W-1:0] i_word,
  output logic [W-1:0] q_word
);
  logic         want_q;
  logic [W-1:0] i_hold;

  assign done   = adv && want_q;
  assign i_word = i_hold;
  assign q_word = word_in;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      want_q <= 1'b0;
      i_hold <= '0;
    end else if (adv) begin
      want_q <= ~want_q;
      if (!want_q) i_hold <= word_in;
    end
  end
endmodule

// File: rtl/iqa_ser_capture.sv
module iqa_ser_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  input  logic         bit_i,
  input  logic         bit_q,
  output logic         done,
  output logic [W-1:0] i_word,
  output logic [W-1:0] q_word
);
  localparam int CNT_W = $clog2(W);
  localparam int LANES = 2;

  logic [CNT_W-1:0] bit_cnt;
  logic [LANES-1:0] lane_bit;
  logic [W-1:0]     lane_word [LANES];

  assign lane_bit = {bit_q, bit_i};
  assign done     = adv && (bit_cnt == CNT_W'(W-1));
  assign i_word   = lane_word[0];
  assign q_word   = lane_word[1];

  always_ff @(posedge clk) begin
    if (rst || clr) bit_cnt <= '0;
    else if (adv)   bit_cnt <= bit_cnt + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] sr_q;
    always_ff @(posedge clk) begin
      if (rst || clr) sr_q <= '0;
      else if (adv)   sr_q <= {sr_q[W-2:0], lane_bit[g]};
    end
    assign lane_word[g] = {sr_q[W-2:0], lane_bit[g]};
  end
endmodule

// File: rtl/iq_input_assembler.sv
module iq_input_assembler
  import iqa_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_half,
  input  logic             dclk_out_en,
  input  logic             mode_sel,
  input  logic             tx_en,
  input  logic [W-1:0]     par_data,
  input  logic             ser_i,
  input  logic             ser_q,
  output logic             data_clk,
  output logic [W-1:0]     i_out,
  output logic [W-1:0]     q_out,
  output logic             out_valid
);
  iqa_mode_e    mode_q;
  logic         rise_stb;
  logic         clr;
  logic         par_adv, ser_adv;
  logic         par_done, ser_done;
  logic [W-1:0] par_i, par_q, ser_iw, ser_qw;

  assign clr     = !tx_en;
  assign par_adv = rise_stb && tx_en && (mode_q == MODE_PAR);
  assign ser_adv = rise_stb && tx_en && (mode_q == MODE_SER);

  iqa_dclk_gen #(.DIV_W(DIV_W)) u_dclk (
    .clk(clk), .rst(rst), .half_cnt(div_half), .pin_en(dclk_out_en),
    .rise_stb(rise_stb), .dclk_pin(data_clk)
  );

  iqa_par_capture #(.W(W)) u_par (
    .clk(clk), .rst(rst), .adv(par_adv), .clr(clr), .word_in(par_data),
    .done(par_done), .i_word(par_i), .q_word(par_q)
  );

  iqa_ser_capture #(.W(W)) u_ser (
    .clk(clk), .rst(rst), .adv(ser_adv), .clr(clr), .bit_i(ser_i),
    .bit_q(ser_q), .done(ser_done), .i_word(ser_iw), .q_word(ser_qw)
  );

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_PAR;
    else if (!tx_en) mode_q <= iqa_mode_e'(mode_sel);
  end

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      i_out     <= '0;
      q_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= par_done || ser_done;
      if (par_done) begin
        i_out <= par_i;
        q_out <= par_q;
      end else if (ser_done) begin
        i_out <= ser_iw;
        q_out <= ser_qw;
      end
    end
  end

  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> (i_out == '0 && q_out == '0 && !out_valid));
  p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_valid_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tx_en));
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(tx_en) |-> mode_q == $past(mode_q));
endmodule

// File: tb/iq_input_assembler_bench.sv
`timescale 1ns/1ps
module iq_input_assembler_bench;
  localparam int W = 16;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_half = 4'd1;
  logic             dclk_out_en = 1'b1;
  logic             mode_sel = 1'b0;
  logic             tx_en = 1'b0;
  logic [W-1:0]     par_data = '0;
  logic             ser_i = 1'b0, ser_q = 1'b0;
  logic             data_clk, out_valid;
  logic [W-1:0]     i_out, q_out;

  int n_cmp = 0, n_bad = 0;
  logic [2*W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  iq_input_assembler #(.W(W), .DIV_W(DIV_W)) u_iq_input_assembler (
    .clk(clk), .rst(rst), .div_half(div_half), .dclk_out_en(dclk_out_en),
    .mode_sel(mode_sel), .tx_en(tx_en), .par_data(par_data), .ser_i(ser_i),
    .ser_q(ser_q), .data_clk(data_clk), .i_out(i_out), .q_out(q_out),
    .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = data_clk;
    forever begin
      @(negedge clk);
      if (data_clk && !prev) break;
      prev = data_clk;
    end
  endtask

  // monitor: pops one expected pair per valid strobe (R3, R4, R5, R7)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected pair actual=%h%h expected=none", i_out, q_out);
      end else begin
        chk("R3/R5 pair", {i_out, q_out}, exp_q.pop_front());
      end
    end
  end

  task automatic par_pair(input logic [W-1:0] iw, input logic [W-1:0] qw);
    par_data = iw;
    wait_rise();
    exp_q.push_back({iw, qw});
    par_data = qw;
    wait_rise();
  endtask

  task automatic ser_pair(input logic [W-1:0] iw, input logic [W-1:0] qw);
    for (int b = W - 1; b >= 0; b--) begin
      ser_i = iw[b];
      ser_q = qw[b];
      if (b == 0) exp_q.push_back({iw, qw});
      wait_rise();
    end
  endtask

  task automatic end_burst_check_flush();
    tx_en = 1'b0;
    @(negedge clk);
    chk("R6 flush i", {16'h0, i_out}, 32'h0);
    chk("R6 flush q", {16'h0, q_out}, 32'h0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    chk("R9 i_out in reset", {16'h0, i_out}, 32'h0);
    chk("R9 valid/dclk in reset", {30'h0, out_valid, data_clk}, 32'h0);
    rst = 1'b0;

    // R1: period with div_half=1 -> 4, then 2 -> 6
    wait_rise(); cyc = 0;
    begin logic p; p = data_clk;
      forever begin @(negedge clk); cyc++; if (data_clk && !p) break; p = data_clk; end
    end
    chk("R1 period div1", cyc, 4);
    div_half = 4'd2;
    wait_rise(); wait_rise(); cyc = 0;
    begin logic p; p = data_clk;
      forever begin @(negedge clk); cyc++; if (data_clk && !p) break; p = data_clk; end
    end
    chk("R1 period div2", cyc, 6);
    div_half = 4'd1;
    wait_rise();

    // R2: pin held low when disabled
    dclk_out_en = 1'b0;
    @(negedge clk);
    cyc = 0;
    repeat (20) begin @(negedge clk); if (data_clk) cyc++; end
    chk("R2 data_clk low while disabled", cyc, 0);
    dclk_out_en = 1'b1;
    wait_rise();

    // R3/R4: parallel burst, mode_sel flipped mid-burst (R8)
    tx_en = 1'b1;
    par_pair(16'h1234, 16'hFEDC);
    @(negedge clk);
    chk("R4 hold after strobe", {i_out, q_out}, 32'h1234FEDC);
    chk("R4 strobe one cycle", {31'h0, out_valid}, 32'h0);
    mode_sel = 1'b1;
    par_pair(16'h8000, 16'h7FFF);
    par_pair(16'h0000, 16'hFFFF);
    end_burst_check_flush();

    // R7: odd word count, then restart aligned on I
    mode_sel = 1'b0;
    wait_rise();
    tx_en = 1'b1;
    par_pair(16'hAAAA, 16'h5555);
    par_data = 16'hDEAD;
    wait_rise();
    tx_en = 1'b0;
    wait_rise();
    tx_en = 1'b1;
    par_pair(16'h0F0F, 16'hF0F0);
    end_burst_check_flush();

    // R5/R8: serial mode latched while idle
    mode_sel = 1'b1;
    wait_rise();
    tx_en = 1'b1;
    ser_pair(16'h8001, 16'h7FFE);
    ser_pair(16'hA5C3, 16'h3C5A);
    end_burst_check_flush();

    // R7: partial serial frame of 7 bits discarded
    wait_rise();
    tx_en = 1'b1;
    for (int b = 0; b < 7; b++) begin ser_i = 1'b1; ser_q = 1'b0; wait_rise(); end
    tx_en = 1'b0;
    wait_rise();
    tx_en = 1'b1;
    ser_pair(16'h1357, 16'hECA8);
    end_burst_check_flush();

    // back to parallel
    mode_sel = 1'b0;
    wait_rise();
    tx_en = 1'b1;
    par_pair(16'h4242, 16'hBDBD);
    end_burst_check_flush();

    repeat (4) @(negedge clk);
    chk("R7 no pending pairs", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule